// File: doc/BRIEF.md
# Jump Target Address Generator

This block holds the program counter of a processor whose program memory is addressed in words, and works out the value it takes next. Each cycle a two-bit mode input picks one of four rules. The first rule steps the counter forward by one. The second adds a signed 12-bit displacement to the counter plus one. The third loads the counter from a 16-bit pointer register. The fourth loads it from that pointer with an extension register placed above it, which lets the target reach past the 16-bit word range of large program memories.

The next value is always visible on a combinational output. The counter register takes that value on a rising clock edge only when the advance input is high. Fetch, decode and the call/return stack sit outside the block and drive its inputs.

Top module: `jump_target_gen`

## Requirements
- R1: When `rst` is high at a rising edge, `pc` is 0 after that edge, whatever `advance` and `mode` are.
- R2: With `mode` = 2'b00 (step), `nextPc` equals `pc` + 1 modulo 2^22.
- R3: With `mode` = 2'b01 (relative), `nextPc` equals `pc` + 1 + k modulo 2^22. Here k is `offset` read as a 12-bit two's-complement value and sign-extended to 22 bits.
- R4: Relative targets reach from 2048 words below `pc` + 1 (`offset` = 12'h800) to 2047 words above it (`offset` = 12'h7FF), so a target can lie behind or ahead of the current word.
- R5: With `mode` = 2'b10 (pointer), `nextPc[15:0]` equals `zPtr` and `nextPc[21:16]` is 0.
- R6: With `mode` = 2'b11 (extended pointer), `nextPc` equals `extReg` in bits 21..16 followed by `zPtr` in bits 15..0.
- R7: On a rising edge with `rst` low, `pc` takes `nextPc` if `advance` is high and keeps its value if `advance` is low.
- R8: `offset` has no effect on `nextPc` outside relative mode. `zPtr` and `extReg` have no effect on `nextPc` in step and relative modes, and `extReg` has no effect in pointer mode.
- R9: Stepping from `pc` = 22'h3FFFFF gives 0. A relative sum that passes either end of the 22-bit space wraps modulo 2^22.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| advance | input | 1 | Lets the counter register take the next value |
| mode | input | 2 | 00 step, 01 relative, 10 pointer, 11 extended pointer |
| offset | input | 12 | Signed relative displacement k |
| zPtr | input | 16 | Pointer register value |
| extReg | input | 6 | Extension bits for the extended pointer mode |
| pc | output | 22 | Current program counter |
| nextPc | output | 22 | Value the counter takes at the next enabled edge |

## Verification
On every cycle the assertions check reset to zero, hold and load of the counter under `advance`, the +1 step, the relative difference between `nextPc` and `pc` + 1, and the bit layout of both pointer modes. Only the bench's scenarios can show the chosen corner cases at work. These are the two extreme displacements, the wrap at the top and bottom of the address space, and the fact that the unused inputs really leave the target unchanged when they are swept during one fixed mode.

// File: rtl/jtg_pkg.sv
package jtg_pkg;

  typedef enum logic [1:0] {
    MODE_STEP = 2'b00,
    MODE_REL  = 2'b01,
    MODE_PTR  = 2'b10,
    MODE_XPTR = 2'b11
  } jtg_mode_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic takeRel;
    logic takePtr;
    logic takeXptr;
    logic loadPc;
  } jtg_strobe_t;

endpackage

// File: rtl/jtg_ctrl.sv
module jtg_ctrl
  import jtg_pkg::*;
(
  input  logic [1:0]  mode,
  input  logic        advance,
  output jtg_strobe_t strobe
);

  jtg_mode_t modeSel;

  assign modeSel = jtg_mode_t'(mode);

  always_comb begin
    strobe = '0;
    strobe.loadPc = advance;
    unique case (modeSel)
      MODE_REL:  strobe.takeRel  = 1'b1;
      MODE_PTR:  strobe.takePtr  = 1'b1;
      MODE_XPTR: strobe.takeXptr = 1'b1;
      default:   ;
    endcase
  end

endmodule

// File: rtl/jtg_datapath.sv
module jtg_datapath
  import jtg_pkg::*;
#(
  parameter int PC_W  = 22,
  parameter int OFS_W = 12,
  parameter int PTR_W = 16,
  localparam int EXT_W = PC_W - PTR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  jtg_strobe_t       strobe,
  input  logic [OFS_W-1:0]  offset,
  input  logic [PTR_W-1:0]  zPtr,
  input  logic [EXT_W-1:0]  extReg,
  output logic [PC_W-1:0]   pc,
  output logic [PC_W-1:0]   nextPc
);

  logic [PC_W-1:0] pcReg;
  logic [PC_W-1:0] stepPc;
  logic [PC_W-1:0] relPc;
  logic [PC_W-1:0] ptrPc;
  logic [PC_W-1:0] xptrPc;
  logic [PC_W-1:0] offsetWide;

  // Sign extension; generate picks the form by width relation
  generate
    if (PC_W > OFS_W) begin : g_sext
      assign offsetWide = {{(PC_W-OFS_W){offset[OFS_W-1]}}, offset};
    end else begin : g_trunc
      assign offsetWide = offset[PC_W-1:0];
    end
  endgenerate

  assign stepPc = pcReg + PC_W'(1);
  assign relPc  = stepPc + offsetWide;
  assign ptrPc  = {{EXT_W{1'b0}}, zPtr};
  assign xptrPc = {extReg, zPtr};

  always_comb begin
    if (strobe.takeXptr)     nextPc = xptrPc;
    else if (strobe.takePtr) nextPc = ptrPc;
    else if (strobe.takeRel) nextPc = relPc;
    else                     nextPc = stepPc;
  end

  always_ff @(posedge clk) begin
    if (rst)                pcReg <= '0;
    else if (strobe.loadPc) pcReg <= nextPc;
  end

  assign pc = pcReg;

endmodule

// File: rtl/jump_target_gen.sv
module jump_target_gen
  import jtg_pkg::*;
#(
  parameter int PC_W  = 22,
  parameter int OFS_W = 12,
  parameter int PTR_W = 16,
  localparam int EXT_W = PC_W - PTR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  input  logic [1:0]        mode,
  input  logic [OFS_W-1:0]  offset,
  input  logic [PTR_W-1:0]  zPtr,
  input  logic [EXT_W-1:0]  extReg,
  output logic [PC_W-1:0]   pc,
  output logic [PC_W-1:0]   nextPc
);

  jtg_strobe_t strobe;

  jtg_ctrl u_ctrl (
    .mode    (mode),
    .advance (advance),
    .strobe  (strobe)
  );

  jtg_datapath #(
    .PC_W  (PC_W),
    .OFS_W (OFS_W),
    .PTR_W (PTR_W)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .offset (offset),
    .zPtr   (zPtr),
    .extReg (extReg),
    .pc     (pc),
    .nextPc (nextPc)
  );

endmodule

// File: rtl/jtg_checker.sv
module jtg_checker #(
  parameter int PC_W  = 22,
  parameter int OFS_W = 12,
  parameter int PTR_W = 16,
  localparam int EXT_W = PC_W - PTR_W
) (
  input logic              clk,
  input logic              rst,
  input logic              advance,
  input logic [1:0]        mode,
  input logic [OFS_W-1:0]  offset,
  input logic [PTR_W-1:0]  zPtr,
  input logic [EXT_W-1:0]  extReg,
  input logic [PC_W-1:0]   pc,
  input logic [PC_W-1:0]   nextPc
);

  logic [PC_W-1:0] relDiff;
  assign relDiff = nextPc - pc - PC_W'(1);

  // R1
  a_r1_reset_zero: assert property (@(posedge clk) rst |=> pc == '0);

  // R7
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(pc));

  // R7
  a_r7_load: assert property (@(posedge clk) disable iff (rst)
    advance |=> pc == $past(nextPc));

  // R2
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    mode == 2'b00 |-> (nextPc - pc) == PC_W'(1));

  // R3
  a_r3_rel_diff: assert property (@(posedge clk) disable iff (rst)
    mode == 2'b01 |-> (relDiff[OFS_W-1:0] == offset &&
      relDiff[PC_W-1:OFS_W] == {(PC_W-OFS_W){offset[OFS_W-1]}}));

  // R5
  a_r5_ptr: assert property (@(posedge clk) disable iff (rst)
    mode == 2'b10 |-> (nextPc[PTR_W-1:0] == zPtr && nextPc[PC_W-1:PTR_W] == '0));

  // R6
  a_r6_xptr: assert property (@(posedge clk) disable iff (rst)
    mode == 2'b11 |-> (nextPc[PTR_W-1:0] == zPtr && nextPc[PC_W-1:PTR_W] == extReg));

endmodule

bind jump_target_gen jtg_checker #(
  .PC_W  (PC_W),
  .OFS_W (OFS_W),
  .PTR_W (PTR_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .advance (advance),
  .mode    (mode),
  .offset  (offset),
  .zPtr    (zPtr),
  .extReg  (extReg),
  .pc      (pc),
  .nextPc  (nextPc)
);

// File: tb/jump_target_gen_tb.sv
`timescale 1ns/1ps
module jump_target_gen_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        advance = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [11:0] offset = '0;
  logic [15:0] zPtr = '0;
  logic [5:0]  extReg = '0;
  logic [21:0] pc;
  logic [21:0] nextPc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  jump_target_gen u_dut (
    .clk(clk), .rst(rst), .advance(advance), .mode(mode),
    .offset(offset), .zPtr(zPtr), .extReg(extReg),
    .pc(pc), .nextPc(nextPc)
  );

  task automatic check(input string tag, input logic [21:0] act, input logic [21:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [21:0] relTarget(input logic [21:0] base, input logic [11:0] k);
    logic signed [23:0] s;
    s = $signed({2'b00, base}) + 24'sd1 + $signed({{12{k[11]}}, k});
    return s[21:0];
  endfunction

  // Puts the counter at v through the extended pointer rule
  task automatic setPc(input logic [21:0] v);
    mode = 2'b11; extReg = v[21:16]; zPtr = v[15:0]; advance = 1'b1;
    tick();
    advance = 1'b0;
  endtask

  task automatic t_reset();
    setPc(22'h2A5A5A);
    rst = 1'b1; advance = 1'b1; mode = 2'b01; offset = 12'h123;
    tick();
    check("R1 pc after reset", pc, 22'h0);
    tick();
    check("R1 pc held in reset", pc, 22'h0);
    rst = 1'b0; advance = 1'b0;
  endtask

  task automatic t_step();
    setPc(22'h001000);
    mode = 2'b00; advance = 1'b1;
    #1 check("R2 step nextPc", nextPc, 22'h001001);
    tick();
    check("R2 step loaded", pc, 22'h001001);
    tick();
    check("R2 second step", pc, 22'h001002);
    advance = 1'b0;
  endtask

  task automatic t_rel();
    setPc(22'h010000);
    mode = 2'b01; offset = 12'h010;
    #1 check("R3 rel +16", nextPc, relTarget(22'h010000, 12'h010));
    offset = 12'hFF0;
    #1 check("R3 rel -16", nextPc, 22'h00FFF1);
    offset = 12'h7FF;
    #1 check("R4 rel max +2047", nextPc, 22'h010800);
    offset = 12'h800;
    #1 check("R4 rel min -2048", nextPc, 22'h00F801);
    offset = 12'hFFF;
    #1 check("R3 rel -1 is self", nextPc, 22'h010000);
    advance = 1'b1; offset = 12'h800;
    tick();
    check("R4 rel loaded", pc, 22'h00F801);
    advance = 1'b0;
  endtask

  task automatic t_ptr();
    setPc(22'h3F0000);
    mode = 2'b10; zPtr = 16'hBEEF; extReg = 6'h3F;
    #1 check("R5 pointer clears upper", nextPc, 22'h00BEEF);
    advance = 1'b1;
    tick();
    check("R5 pointer loaded", pc, 22'h00BEEF);
    advance = 1'b0;
  endtask

  task automatic t_xptr();
    mode = 2'b11; zPtr = 16'h1234; extReg = 6'h2B;
    #1 check("R6 extended pointer", nextPc, {6'h2B, 16'h1234});
    advance = 1'b1;
    tick();
    check("R6 extended loaded", pc, 22'h2B1234);
    advance = 1'b0;
  endtask

  task automatic t_hold();
    setPc(22'h055555);
    mode = 2'b11; zPtr = 16'h0000; extReg = 6'h00; advance = 1'b0;
    tick();
    check("R7 hold with advance low", pc, 22'h055555);
    mode = 2'b00;
    tick();
    check("R7 hold in step mode", pc, 22'h055555);
  endtask

  task automatic t_ignore();
    setPc(22'h000400);
    mode = 2'b00; offset = 12'h7AB; zPtr = 16'hFFFF; extReg = 6'h15;
    #1 check("R8 step ignores offset/z/ext", nextPc, 22'h000401);
    mode = 2'b01; offset = 12'h002; zPtr = 16'h1111; extReg = 6'h2A;
    #1 check("R8 rel ignores z/ext", nextPc, 22'h000403);
    mode = 2'b10; offset = 12'h555; extReg = 6'h01; zPtr = 16'h0042;
    #1 check("R8 pointer ignores offset/ext", nextPc, 22'h000042);
    mode = 2'b11; offset = 12'hAAA;
    #1 check("R8 xptr ignores offset", nextPc, 22'h010042);
  endtask

  task automatic t_wrap();
    setPc(22'h3FFFFF);
    mode = 2'b00; advance = 1'b1;
    tick();
    check("R9 step wraps to zero", pc, 22'h0);
    advance = 1'b0;
    mode = 2'b01; offset = 12'h800;
    #1 check("R9 rel wraps below zero", nextPc, 22'h3FF801);
    setPc(22'h3FFFF0);
    mode = 2'b01; offset = 12'h020;
    #1 check("R9 rel wraps above top", nextPc, 22'h000011);
  endtask

  initial begin
    rst = 1'b1;
    tick();
    tick();
    check("R1 reset state", pc, 22'h0);
    rst = 1'b0;
    t_reset();
    t_step();
    t_rel();
    t_ptr();
    t_xptr();
    t_hold();
    t_ignore();
    t_wrap();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule